// File: doc/BRIEF.md
# Tagged AXI4 SRAM Slave

This block is an AXI4 memory slave in front of a 128 KiB on-chip memory with a 64-bit data path. Next to the data it holds one validity tag bit for every 16-byte capability slot, which is two data words. Tags enter on the write user bit and leave on the read user bit. Read and write channels run independently. Each channel is a small state machine that handles one incremental burst at a time. Every response echoes the ID of its request.

A write with any byte strobe low clears the tag of the slot it touches. A read narrower than 64 bits returns its data with the reported tag forced to zero and leaves the stored tag alone. Each beat is checked against the end of memory on its own. A beat past the end gets SLVERR: a read beat returns zero, and a write beat changes nothing. In-range beats of the same burst complete normally. Lock (exclusive) requests are served as ordinary accesses.

The write channel has three states:
- `WR_IDLE` (address ready) goes to `WR_DATA` on an address handshake.
- `WR_DATA` (data ready) stays there until the expected final beat is accepted, then goes to `WR_RESP`.
- `WR_RESP` (response valid) returns to `WR_IDLE` on the response handshake.

The read channel also has three states:
- `RD_IDLE` (address ready) goes to `RD_FETCH` on an address handshake.
- `RD_FETCH` reads the memory for one cycle and always goes to `RD_SEND`.
- `RD_SEND` (data valid) goes to `RD_IDLE` on the handshake of the final beat, and back to `RD_FETCH` on any other beat.

Reset returns both machines to their idle states.

Top module: `tagged_axi_sram`

## Requirements
- R1: While reset is low and after it is released, awready and arready are 1 and wready, bvalid and rvalid are 0. A reset in the middle of a burst drops that burst, and the next transaction completes normally.
- R2: Data written with full strobes reads back unchanged. The first read beat is valid two rising edges after the read address handshake, and each later beat two edges after the previous beat's handshake. bvalid rises on the edge that accepts the final write beat.
- R3: rid equals the arid of the burst being served, and bid equals the awid of the burst being answered.
- R4: rlast is 1 on exactly beat number arlen (counting from 0) of each read burst.
- R5: A write burst always takes awlen+1 data beats. If wlast differs on any beat from "this is beat awlen", bresp is SLVERR (2'b10). Otherwise bresp is OKAY (2'b00).
- R6: A write beat with all eight strobes set stores wuser as the tag of its slot, where the slot is address bits [16:4]. A 64-bit read (arsize 3) returns that slot's tag on ruser.
- R7: A write beat with any strobe low writes only the enabled bytes and clears the tag of its slot.
- R8: A read with arsize below 3 returns the full addressed word with ruser 0. The stored tag is unchanged and a later 64-bit read still reports it.
- R9: A read beat at byte address 0x20000 or above gets rresp SLVERR, rdata 0 and ruser 0. In-range beats of the same burst return OKAY with their data.
- R10: A write beat at byte address 0x20000 or above changes no memory and no tag, and makes the burst's bresp SLVERR. In-range beats of that burst are still written.
- R11: awlock and arlock do not change behaviour. Locked accesses return OKAY and never EXOKAY (2'b01).
- R12: While rready or bready is low, rvalid or bvalid stays 1 with its payload stable. arready is 0 while a read burst is in progress, and awready is 0 while a write burst is in progress.
- R13: Inside a burst the address advances by 2^size bytes per beat, so narrow beats step through the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| awid | input | ID_W | Write request ID |
| awaddr | input | ADDR_W | Write start byte address |
| awlen | input | 8 | Write beats minus one |
| awsize | input | 3 | Write beat size, log2 bytes |
| awlock | input | 1 | Exclusive flag, treated as normal |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| wdata | input | DATA_W | Write data |
| wstrb | input | DATA_W/8 | Write byte enables |
| wlast | input | 1 | Final write beat marker |
| wuser | input | 1 | Tag bit for the beat's slot |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| bid | output | ID_W | Write response ID |
| bresp | output | 2 | Write response code |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| arid | input | ID_W | Read request ID |
| araddr | input | ADDR_W | Read start byte address |
| arlen | input | 8 | Read beats minus one |
| arsize | input | 3 | Read beat size, log2 bytes |
| arlock | input | 1 | Exclusive flag, treated as normal |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| rid | output | ID_W | Read response ID |
| rdata | output | DATA_W | Read data |
| rresp | output | 2 | Read response code |
| rlast | output | 1 | Final read beat marker |
| ruser | output | 1 | Tag bit of the beat's slot |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |

## Verification
The ready outputs follow the channel state, so they change one rising edge after an address handshake. A read beat turns valid two edges after the handshake that started it, and the write response turns valid on the edge that takes the final data beat. The bench drives and samples only on falling edges, so every registered change has settled before it looks. In every read it counts the falling edges from the handshake to rvalid and expects exactly one wait. In every write it expects bvalid at the first falling edge after the last beat. The backpressure tests hold the ready inputs low for a fixed number of cycles and then compare the held payload with the value expected at that cycle.

// File: rtl/tsram_pkg.sv
package tsram_pkg;

    typedef enum logic [1:0] {
        WR_IDLE,
        WR_DATA,
        WR_RESP
    } wr_state_e;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_FETCH,
        RD_SEND
    } rd_state_e;

    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_EXOKAY = 2'b01;
    localparam logic [1:0] RESP_SLVERR = 2'b10;

endpackage

// File: rtl/tsram_store.sv
module tsram_store #(
    parameter int DATA_W     = 64,
    parameter int WORD_IDX_W = 14
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [WORD_IDX_W-1:0]   wr_idx,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic [DATA_W/8-1:0]     wr_strb,
    input  logic                    wr_tag,
    input  logic                    rd_en,
    input  logic [WORD_IDX_W-1:0]   rd_idx,
    output logic [DATA_W-1:0]       rd_data,
    output logic                    rd_tag
);

    localparam int STRB_W = DATA_W / 8;
    localparam int SLOT_W = WORD_IDX_W - 1;
    localparam int SLOTS  = 1 << SLOT_W;

    logic [SLOT_W-1:0] wr_slot;
    logic [SLOT_W-1:0] rd_slot;
    logic [DATA_W-1:0] bank_rd [2];
    logic              half_q;
    logic              tags [SLOTS];

    assign wr_slot = wr_idx[WORD_IDX_W-1:1];
    assign rd_slot = rd_idx[WORD_IDX_W-1:1];

    // Each slot is split over two banks: even word and odd word.
    for (genvar h = 0; h < 2; h++) begin : g_bank
        logic [DATA_W-1:0] mem [SLOTS];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx[0] == 1'(h))) begin
                for (int b = 0; b < STRB_W; b++) begin
                    if (wr_strb[b]) begin
                        mem[wr_slot][b*8 +: 8] <= wr_data[b*8 +: 8];
                    end
                end
            end
            if (rd_en) begin
                bank_rd[h] <= mem[rd_slot];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tags[wr_slot] <= (&wr_strb) ? wr_tag : 1'b0;
        end
        if (rd_en) begin
            rd_tag <= tags[rd_slot];
            half_q <= rd_idx[0];
        end
    end

    assign rd_data = half_q ? bank_rd[1] : bank_rd[0];

endmodule

// File: rtl/tsram_wr_ch.sv
module tsram_wr_ch
    import tsram_pkg::*;
#(
    parameter int ID_W       = 4,
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 64,
    parameter int MEM_BYTES  = 131072,
    parameter int WORD_IDX_W = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ID_W-1:0]         awid,
    input  logic [ADDR_W-1:0]       awaddr,
    input  logic [7:0]              awlen,
    input  logic [2:0]              awsize,
    input  logic                    awvalid,
    output logic                    awready,
    input  logic                    wlast,
    input  logic                    wvalid,
    output logic                    wready,
    output logic [ID_W-1:0]         bid,
    output logic [1:0]              bresp,
    output logic                    bvalid,
    input  logic                    bready,
    output logic                    st_we,
    output logic [WORD_IDX_W-1:0]   st_idx
);

    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(MEM_BYTES);

    wr_state_e         state_q, state_d;
    logic [ID_W-1:0]   id_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        len_q, cnt_q;
    logic [2:0]        size_q;
    logic              err_q;
    logic              beat_oor;
    logic              last_exp;
    logic              aw_fire, w_fire;

    assign beat_oor = ({1'b0, addr_q} >= LIMIT);
    assign last_exp = (cnt_q == len_q);
    assign aw_fire  = awvalid && (state_q == WR_IDLE);
    assign w_fire   = wvalid && (state_q == WR_DATA);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WR_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WR_IDLE: if (awvalid)             state_d = WR_DATA;
            WR_DATA: if (wvalid && last_exp)  state_d = WR_RESP;
            WR_RESP: if (bready)              state_d = WR_IDLE;
            default:                          state_d = WR_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        awready = (state_q == WR_IDLE);
        wready  = (state_q == WR_DATA);
        bvalid  = (state_q == WR_RESP);
        bid     = id_q;
        bresp   = err_q ? RESP_SLVERR : RESP_OKAY;
        st_we   = w_fire && !beat_oor;
        st_idx  = addr_q[WORD_IDX_W+2:3];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_q   <= '0;
            addr_q <= '0;
            len_q  <= '0;
            cnt_q  <= '0;
            size_q <= '0;
            err_q  <= 1'b0;
        end else if (aw_fire) begin
            id_q   <= awid;
            addr_q <= awaddr;
            len_q  <= awlen;
            size_q <= awsize;
            cnt_q  <= '0;
            err_q  <= 1'b0;
        end else if (w_fire) begin
            err_q  <= err_q | beat_oor | (wlast != last_exp);
            addr_q <= addr_q + (ADDR_W'(1) << size_q);
            cnt_q  <= cnt_q + 8'd1;
        end
    end

endmodule

// File: rtl/tsram_rd_ch.sv
module tsram_rd_ch
    import tsram_pkg::*;
#(
    parameter int ID_W       = 4,
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 64,
    parameter int MEM_BYTES  = 131072,
    parameter int WORD_IDX_W = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ID_W-1:0]         arid,
    input  logic [ADDR_W-1:0]       araddr,
    input  logic [7:0]              arlen,
    input  logic [2:0]              arsize,
    input  logic                    arvalid,
    output logic                    arready,
    output logic [ID_W-1:0]         rid,
    output logic [DATA_W-1:0]       rdata,
    output logic [1:0]              rresp,
    output logic                    rlast,
    output logic                    ruser,
    output logic                    rvalid,
    input  logic                    rready,
    output logic                    st_re,
    output logic [WORD_IDX_W-1:0]   st_idx,
    input  logic [DATA_W-1:0]       st_data,
    input  logic                    st_tag
);

    localparam logic [ADDR_W:0] LIMIT     = (ADDR_W+1)'(MEM_BYTES);
    localparam logic [2:0]      FULL_SIZE = 3'($clog2(DATA_W / 8));

    rd_state_e         state_q, state_d;
    logic [ID_W-1:0]   id_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        len_q, cnt_q;
    logic [2:0]        size_q;
    logic              beat_oor;
    logic              last_beat;
    logic              ar_fire, r_fire;

    assign beat_oor  = ({1'b0, addr_q} >= LIMIT);
    assign last_beat = (cnt_q == len_q);
    assign ar_fire   = arvalid && (state_q == RD_IDLE);
    assign r_fire    = rready && (state_q == RD_SEND);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE:  if (arvalid) state_d = RD_FETCH;
            RD_FETCH:              state_d = RD_SEND;
            RD_SEND:  if (rready)  state_d = last_beat ? RD_IDLE : RD_FETCH;
            default:               state_d = RD_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        arready = (state_q == RD_IDLE);
        rvalid  = (state_q == RD_SEND);
        rid     = id_q;
        rlast   = last_beat;
        rresp   = beat_oor ? RESP_SLVERR : RESP_OKAY;
        rdata   = beat_oor ? '0 : st_data;
        ruser   = !beat_oor && (size_q >= FULL_SIZE) && st_tag;
        st_re   = (state_q == RD_FETCH) && !beat_oor;
        st_idx  = addr_q[WORD_IDX_W+2:3];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_q   <= '0;
            addr_q <= '0;
            len_q  <= '0;
            cnt_q  <= '0;
            size_q <= '0;
        end else if (ar_fire) begin
            id_q   <= arid;
            addr_q <= araddr;
            len_q  <= arlen;
            size_q <= arsize;
            cnt_q  <= '0;
        end else if (r_fire) begin
            addr_q <= addr_q + (ADDR_W'(1) << size_q);
            cnt_q  <= cnt_q + 8'd1;
        end
    end

endmodule

// File: rtl/tagged_axi_sram.sv
module tagged_axi_sram #(
    parameter int ID_W      = 4,
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 64,
    parameter int MEM_BYTES = 131072
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ID_W-1:0]     awid,
    input  logic [ADDR_W-1:0]   awaddr,
    input  logic [7:0]          awlen,
    input  logic [2:0]          awsize,
    input  logic                awlock,
    input  logic                awvalid,
    output logic                awready,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W/8-1:0] wstrb,
    input  logic                wlast,
    input  logic                wuser,
    input  logic                wvalid,
    output logic                wready,
    output logic [ID_W-1:0]     bid,
    output logic [1:0]          bresp,
    output logic                bvalid,
    input  logic                bready,
    input  logic [ID_W-1:0]     arid,
    input  logic [ADDR_W-1:0]   araddr,
    input  logic [7:0]          arlen,
    input  logic [2:0]          arsize,
    input  logic                arlock,
    input  logic                arvalid,
    output logic                arready,
    output logic [ID_W-1:0]     rid,
    output logic [DATA_W-1:0]   rdata,
    output logic [1:0]          rresp,
    output logic                rlast,
    output logic                ruser,
    output logic                rvalid,
    input  logic                rready
);

    localparam int WORD_IDX_W = $clog2(MEM_BYTES / (DATA_W / 8));

    logic                  wr_en, rd_en;
    logic [WORD_IDX_W-1:0] wr_idx, rd_idx;
    logic [DATA_W-1:0]     rd_word;
    logic                  rd_tag;

    // Lock requests are served as plain accesses.
    logic unused_lock;
    assign unused_lock = awlock ^ arlock;

    tsram_wr_ch #(
        .ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .MEM_BYTES(MEM_BYTES), .WORD_IDX_W(WORD_IDX_W)
    ) u_wr (
        .clk(clk), .rst_n(rst_n),
        .awid(awid), .awaddr(awaddr), .awlen(awlen), .awsize(awsize),
        .awvalid(awvalid), .awready(awready),
        .wlast(wlast), .wvalid(wvalid), .wready(wready),
        .bid(bid), .bresp(bresp), .bvalid(bvalid), .bready(bready),
        .st_we(wr_en), .st_idx(wr_idx)
    );

    tsram_rd_ch #(
        .ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .MEM_BYTES(MEM_BYTES), .WORD_IDX_W(WORD_IDX_W)
    ) u_rd (
        .clk(clk), .rst_n(rst_n),
        .arid(arid), .araddr(araddr), .arlen(arlen), .arsize(arsize),
        .arvalid(arvalid), .arready(arready),
        .rid(rid), .rdata(rdata), .rresp(rresp), .rlast(rlast),
        .ruser(ruser), .rvalid(rvalid), .rready(rready),
        .st_re(rd_en), .st_idx(rd_idx), .st_data(rd_word), .st_tag(rd_tag)
    );

    tsram_store #(
        .DATA_W(DATA_W), .WORD_IDX_W(WORD_IDX_W)
    ) u_store (
        .clk(clk),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wdata), .wr_strb(wstrb),
        .wr_tag(wuser),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_word), .rd_tag(rd_tag)
    );

endmodule

// File: rtl/tsram_checker.sv
module tsram_checker
    import tsram_pkg::*;
#(
    parameter int ID_W   = 4,
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ID_W-1:0]   awid,
    input logic              awvalid,
    input logic              awready,
    input logic              wready,
    input logic [ID_W-1:0]   bid,
    input logic [1:0]        bresp,
    input logic              bvalid,
    input logic              bready,
    input logic [ID_W-1:0]   arid,
    input logic [7:0]        arlen,
    input logic [2:0]        arsize,
    input logic              arvalid,
    input logic              arready,
    input logic [ID_W-1:0]   rid,
    input logic [DATA_W-1:0] rdata,
    input logic [1:0]        rresp,
    input logic              rlast,
    input logic              ruser,
    input logic              rvalid,
    input logic              rready
);

    localparam logic [2:0] FULL_SIZE = 3'($clog2(DATA_W / 8));

    logic [ID_W-1:0] ar_id_q, aw_id_q;
    logic [7:0]      ar_len_q, beat_q;
    logic            ar_narrow_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ar_id_q     <= '0;
            aw_id_q     <= '0;
            ar_len_q    <= '0;
            beat_q      <= '0;
            ar_narrow_q <= 1'b0;
        end else begin
            if (arvalid && arready) begin
                ar_id_q     <= arid;
                ar_len_q    <= arlen;
                ar_narrow_q <= (arsize < FULL_SIZE);
                beat_q      <= '0;
            end else if (rvalid && rready) begin
                beat_q <= beat_q + 8'd1;
            end
            if (awvalid && awready) aw_id_q <= awid;
        end
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!rvalid && !bvalid && !wready));

    a_r3_rid_match: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> rid == ar_id_q);

    a_r3_bid_match: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid |-> bid == aw_id_q);

    a_r4_last_beat: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> rlast == (beat_q == ar_len_q));

    a_r8_narrow_tag: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && ar_narrow_q) |-> !ruser);

    a_r9_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && rresp == RESP_SLVERR) |-> (rdata == '0 && !ruser));

    a_r11_no_exokay: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid |-> rresp != RESP_EXOKAY) and (bvalid |-> bresp != RESP_EXOKAY));

    a_r12_r_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !rready) |=> (rvalid && $stable(rdata) && $stable(rid)
                                 && $stable(rlast) && $stable(rresp) && $stable(ruser)));

    a_r12_b_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && !bready) |=> (bvalid && $stable(bid) && $stable(bresp)));

    a_r12_ar_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> !arready);

endmodule

bind tagged_axi_sram tsram_checker #(.ID_W(ID_W), .DATA_W(DATA_W)) u_tsram_checker (.*);

// File: tb/test_tagged_axi_sram.sv
`timescale 1ns/1ps
module test_tagged_axi_sram;

    typedef struct packed {
        logic        rd;
        logic [3:0]  id;
        logic [31:0] addr;
        logic [7:0]  len;
        logic        lock;
        logic        tag;
        logic [31:0] seed;
    } vec_t;

    // write rows store pattern(seed); read rows expect pattern(seed) and tag
    localparam vec_t VECS [8] = '{
        '{1'b0, 4'd3, 32'h0000_0100, 8'd3, 1'b0, 1'b1, 32'd11},
        '{1'b1, 4'd5, 32'h0000_0100, 8'd3, 1'b0, 1'b1, 32'd11},
        '{1'b0, 4'd1, 32'h0000_2000, 8'd0, 1'b0, 1'b0, 32'd22},
        '{1'b1, 4'd2, 32'h0000_2000, 8'd0, 1'b0, 1'b0, 32'd22},
        '{1'b0, 4'd7, 32'h0001_FFF0, 8'd1, 1'b0, 1'b1, 32'd33},
        '{1'b1, 4'd4, 32'h0001_FFF0, 8'd1, 1'b0, 1'b1, 32'd33},
        '{1'b0, 4'd2, 32'h0000_0400, 8'd7, 1'b1, 1'b1, 32'd44},
        '{1'b1, 4'd6, 32'h0000_0400, 8'd7, 1'b1, 1'b1, 32'd44}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  awid = '0, arid = '0, bid, rid;
    logic [31:0] awaddr = '0, araddr = '0;
    logic [7:0]  awlen = '0, arlen = '0;
    logic [2:0]  awsize = '0, arsize = '0;
    logic        awlock = 1'b0, arlock = 1'b0;
    logic        awvalid = 1'b0, arvalid = 1'b0, wvalid = 1'b0;
    logic        bready = 1'b0, rready = 1'b0;
    logic [63:0] wdata = '0, rdata;
    logic [7:0]  wstrb = '0;
    logic        wlast = 1'b0, wuser = 1'b0;
    logic        awready, wready, bvalid, arready, rlast, ruser, rvalid;
    logic [1:0]  bresp, rresp;

    int checks = 0;
    int errors = 0;

    logic [63:0] got_data [256];
    logic [1:0]  got_resp [256];
    logic        got_last [256];
    logic        got_user [256];
    logic [3:0]  got_id   [256];
    int          rd_wait_bad;
    logic [3:0]  got_bid;
    logic [1:0]  got_bresp;
    int          b_wait;

    always #10 clk = ~clk;

    tagged_axi_sram i_tagged_axi_sram (
        .clk(clk), .rst_n(rst_n),
        .awid(awid), .awaddr(awaddr), .awlen(awlen), .awsize(awsize),
        .awlock(awlock), .awvalid(awvalid), .awready(awready),
        .wdata(wdata), .wstrb(wstrb), .wlast(wlast), .wuser(wuser),
        .wvalid(wvalid), .wready(wready),
        .bid(bid), .bresp(bresp), .bvalid(bvalid), .bready(bready),
        .arid(arid), .araddr(araddr), .arlen(arlen), .arsize(arsize),
        .arlock(arlock), .arvalid(arvalid), .arready(arready),
        .rid(rid), .rdata(rdata), .rresp(rresp), .rlast(rlast),
        .ruser(ruser), .rvalid(rvalid), .rready(rready)
    );

    function automatic logic [63:0] pat(input logic [31:0] seed, input int beat);
        return {seed, 32'hA500_0000 + 32'(beat)};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic aw_send(input logic [3:0] id, input logic [31:0] addr,
                           input logic [7:0] len, input logic [2:0] size, input logic lock);
        @(negedge clk);
        awid = id; awaddr = addr; awlen = len; awsize = size; awlock = lock; awvalid = 1'b1;
        while (!awready) @(negedge clk);
        @(negedge clk);
        awvalid = 1'b0; awlock = 1'b0;
    endtask

    // mode 0: correct wlast, 1: never set, 2: set on every beat
    task automatic w_beats(input int nbeats, input logic [7:0] strb, input logic tag,
                           input logic [31:0] seed, input int mode);
        for (int i = 0; i < nbeats; i++) begin
            wdata = pat(seed, i); wstrb = strb; wuser = tag;
            wlast = (mode == 2) || (mode == 0 && i == nbeats - 1);
            wvalid = 1'b1;
            while (!wready) @(negedge clk);
            @(negedge clk);
        end
        wvalid = 1'b0; wlast = 1'b0;
    endtask

    task automatic b_take();
        bready = 1'b1;
        b_wait = 0;
        while (!bvalid) begin
            @(negedge clk);
            b_wait++;
        end
        got_bid = bid; got_bresp = bresp;
        @(negedge clk);
        bready = 1'b0;
    endtask

    task automatic do_write(input logic [3:0] id, input logic [31:0] addr, input logic [7:0] len,
                            input logic [7:0] strb, input logic tag, input logic [31:0] seed,
                            input int mode, input logic lock);
        aw_send(id, addr, len, 3'd3, lock);
        w_beats(int'(len) + 1, strb, tag, seed, mode);
        b_take();
    endtask

    task automatic do_read(input logic [3:0] id, input logic [31:0] addr, input logic [7:0] len,
                           input logic [2:0] size, input logic lock);
        int waits;
        aw_dummy: begin end
        @(negedge clk);
        arid = id; araddr = addr; arlen = len; arsize = size; arlock = lock; arvalid = 1'b1;
        while (!arready) @(negedge clk);
        @(negedge clk);
        arvalid = 1'b0; arlock = 1'b0;
        rready = 1'b1;
        rd_wait_bad = 0;
        for (int i = 0; i <= int'(len); i++) begin
            waits = 0;
            while (!rvalid) begin
                @(negedge clk);
                waits++;
            end
            if (waits != 1) rd_wait_bad++;
            got_data[i] = rdata; got_resp[i] = rresp; got_last[i] = rlast;
            got_user[i] = ruser; got_id[i] = rid;
            @(negedge clk);
        end
        rready = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 awready in reset", 64'(awready), 64'd1);
        chk("R1 arready in reset", 64'(arready), 64'd1);
        chk("R1 wready/bvalid/rvalid in reset", 64'({wready, bvalid, rvalid}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", 64'({awready, arready, wready, bvalid, rvalid}), 64'b11000);

        // table walk: R2 R3 R4 R6 R11
        for (int v = 0; v < 8; v++) begin
            if (!VECS[v].rd) begin
                do_write(VECS[v].id, VECS[v].addr, VECS[v].len, 8'hFF, VECS[v].tag,
                         VECS[v].seed, 0, VECS[v].lock);
                chk("R3 bid", 64'(got_bid), 64'(VECS[v].id));
                chk("R11 bresp OKAY", 64'(got_bresp), 64'd0);
                chk("R2 bvalid latency", 64'(b_wait), 64'd0);
            end else begin
                do_read(VECS[v].id, VECS[v].addr, VECS[v].len, 3'd3, VECS[v].lock);
                chk("R2 read latency", 64'(rd_wait_bad), 64'd0);
                for (int i = 0; i <= int'(VECS[v].len); i++) begin
                    chk("R2 rdata", got_data[i], pat(VECS[v].seed, i));
                    chk("R3 rid", 64'(got_id[i]), 64'(VECS[v].id));
                    chk("R4 rlast", 64'(got_last[i]), 64'(i == int'(VECS[v].len)));
                    chk("R6 ruser tag", 64'(got_user[i]), 64'(VECS[v].tag));
                    chk("R11 rresp OKAY", 64'(got_resp[i]), 64'd0);
                end
            end
        end

        // R7: partial write clears tag and merges bytes
        do_write(4'd1, 32'h800, 8'd1, 8'hFF, 1'b1, 32'd55, 0, 1'b0);
        do_write(4'd1, 32'h808, 8'd0, 8'h0F, 1'b1, 32'd66, 0, 1'b0);
        do_read(4'd2, 32'h800, 8'd1, 3'd3, 1'b0);
        chk("R7 untouched word", got_data[0], pat(32'd55, 0));
        chk("R7 merged bytes", got_data[1], {32'd55, 32'hA500_0000});
        chk("R7 tag cleared beat0", 64'(got_user[0]), 64'd0);
        chk("R7 tag cleared beat1", 64'(got_user[1]), 64'd0);

        // R8 / R13: narrow read hides tag, steps inside word
        do_write(4'd3, 32'hC00, 8'd1, 8'hFF, 1'b1, 32'd77, 0, 1'b0);
        do_read(4'd4, 32'hC00, 8'd1, 3'd2, 1'b0);
        chk("R13 narrow beat0", got_data[0], pat(32'd77, 0));
        chk("R13 narrow beat1 same word", got_data[1], pat(32'd77, 0));
        chk("R8 narrow ruser", 64'({got_user[0], got_user[1]}), 64'd0);
        do_read(4'd4, 32'hC00, 8'd0, 3'd3, 1'b0);
        chk("R8 stored tag kept", 64'(got_user[0]), 64'd1);

        // R9: read burst crossing the end of memory
        do_read(4'd9, 32'h1FFF8, 8'd2, 3'd3, 1'b0);
        chk("R9 in-range beat", got_data[0], pat(32'd33, 1));
        chk("R9 in-range resp", 64'(got_resp[0]), 64'd0);
        chk("R9 in-range tag", 64'(got_user[0]), 64'd1);
        chk("R9 oor resp", 64'({got_resp[1], got_resp[2]}), 64'b1010);
        chk("R9 oor data", got_data[1] | got_data[2], 64'd0);
        chk("R9 oor tag", 64'({got_user[1], got_user[2]}), 64'd0);
        chk("R4 rlast on oor beat", 64'({got_last[0], got_last[1], got_last[2]}), 64'b001);

        // R10: write burst crossing the end of memory
        do_write(4'd5, 32'h0, 8'd0, 8'hFF, 1'b1, 32'd99, 0, 1'b0);
        do_write(4'd6, 32'h1FFF8, 8'd1, 8'hFF, 1'b0, 32'd88, 0, 1'b0);
        chk("R10 bresp SLVERR", 64'(got_bresp), 64'd2);
        do_read(4'd1, 32'h1FFF8, 8'd0, 3'd3, 1'b0);
        chk("R10 in-range beat written", got_data[0], pat(32'd88, 0));
        do_read(4'd1, 32'h0, 8'd0, 3'd3, 1'b0);
        chk("R10 no wrap write", got_data[0], pat(32'd99, 0));
        chk("R10 no wrap tag", 64'(got_user[0]), 64'd1);

        // R5: wlast mismatch
        do_write(4'd2, 32'h600, 8'd1, 8'hFF, 1'b0, 32'd5, 1, 1'b0);
        chk("R5 missing wlast", 64'(got_bresp), 64'd2);
        do_write(4'd2, 32'h600, 8'd1, 8'hFF, 1'b0, 32'd6, 2, 1'b0);
        chk("R5 early wlast", 64'(got_bresp), 64'd2);
        do_read(4'd2, 32'h600, 8'd1, 3'd3, 1'b0);
        chk("R5 all beats consumed", got_data[1], pat(32'd6, 1));

        // R12: read backpressure
        @(negedge clk);
        arid = 4'd8; araddr = 32'h100; arlen = 8'd1; arsize = 3'd3; arvalid = 1'b1;
        @(negedge clk);
        arvalid = 1'b0;
        repeat (6) @(negedge clk);
        chk("R12 rvalid held", 64'(rvalid), 64'd1);
        chk("R12 arready low busy", 64'(arready), 64'd0);
        chk("R12 held data", rdata, pat(32'd11, 0));
        chk("R4 not last beat0", 64'(rlast), 64'd0);
        rready = 1'b1;
        @(negedge clk);
        rready = 1'b0;
        chk("R2 fetch gap", 64'(rvalid), 64'd0);
        repeat (4) @(negedge clk);
        chk("R12 beat1 data", rdata, pat(32'd11, 1));
        chk("R4 last beat1", 64'(rlast), 64'd1);
        rready = 1'b1;
        @(negedge clk);
        rready = 1'b0;
        chk("R12 arready back", 64'(arready), 64'd1);

        // R12: write response backpressure
        aw_send(4'd12, 32'hA00, 8'd0, 3'd3, 1'b0);
        chk("R12 awready low busy", 64'(awready), 64'd0);
        w_beats(1, 8'hFF, 1'b0, 32'd7, 0);
        repeat (4) @(negedge clk);
        chk("R12 bvalid held", 64'(bvalid), 64'd1);
        chk("R12 bid held", 64'(bid), 64'd12);
        b_take();

        // R1: reset in the middle of a write burst
        aw_send(4'd3, 32'h900, 8'd3, 3'd3, 1'b0);
        w_beats(1, 8'hFF, 1'b1, 32'd100, 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid-burst reset idle", 64'({awready, wready, bvalid}), 64'b100);
        rst_n = 1'b1;
        do_write(4'd4, 32'h980, 8'd1, 8'hFF, 1'b1, 32'd111, 0, 1'b0);
        chk("R1 recovery bresp", 64'({got_bid, got_bresp}), {58'd0, 4'd4, 2'd0});
        do_read(4'd5, 32'h980, 8'd1, 3'd3, 1'b0);
        chk("R1 recovery data", got_data[1], pat(32'd111, 1));
        chk("R1 recovery tag", 64'(got_user[0]), 64'd1);

        finish_run();
    end

endmodule